// File: doc/BRIEF.md
# DRAM Self-Refresh Entry and Exit Sequencer

This block sits on the controller side of a DDR SDRAM interface. It owns the clock-enable pin and the four command strobes while a memory rank goes into self-refresh and comes back out. A one-cycle sleep pulse starts entry. The sequencer then issues the refresh command encoding in the same cycle that it pulls the clock enable low, and it acknowledges once the memory is retaining data on its own. The caller must have closed every bank before it asks.

A one-cycle wake pulse starts exit. The sequencer keeps the clock enable low until the clock-stable input reports a settled clock. It then raises the clock enable and sends NOPs for a configurable exit window. After that window it grants general commands. Reads stay forbidden until the memory's delay-locked loop has had its full relock period. A conservative build parameter stretches the NOP window to cover that whole period, so that no command of any kind is granted before it ends. All timings are parameters counted in clock cycles.

Top module: `sr_seq_top`

## Requirements
- R1: A sleep pulse accepted in the idle state gives exactly one cycle, starting the cycle after the pulse, in which the clock enable is low and the command strobes carry refresh ({cs_n,ras_n,cas_n,we_n} = 4'b0001).
- R2: While the clock enable is held low after that entry cycle, the strobes stay parked at NOP (4'b0111), the acknowledge is high, and both the general and read enables are low.
- R3: After a wake, the clock enable stays low for as long as the clock-stable input is low, and it rises in the cycle after the clock-stable input is first sampled high.
- R4: For the first TXSNR cycles with the clock enable high, the strobes carry NOP and the general command enable is low. It rises in cycle TXSNR, counting the first high cycle as 0.
- R5: The read enable stays low for the first DLL_CYC cycles with the clock enable high and rises in cycle DLL_CYC. The read enable is never high while the general enable is low.
- R6: With CONSERVATIVE set, the general command enable also stays low for the first DLL_CYC cycles after the clock enable rises.
- R7: A wake pulse that arrives in the entry cycle is held. Self-refresh is still entered and acknowledged, and exit then follows without a further wake pulse.
- R8: A sleep pulse outside the idle state and a wake pulse outside the entry and self-refresh states have no effect: the clock enable and enables follow their undisturbed course.
- R9: A synchronous active-high reset returns the block to idle in the following cycle: clock enable high, NOP on the strobes, both enables high and the acknowledge low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | One-cycle pulse requesting self-refresh entry |
| wake_req | input | 1 | One-cycle pulse requesting self-refresh exit |
| clk_stable | input | 1 | High when the memory clock is stable |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_cs_n | output | 1 | Chip select strobe, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| cmd_en | output | 1 | High when non-read commands may be issued |
| rd_en | output | 1 | High when reads may be issued |
| sr_ack | output | 1 | High while the memory is held in self-refresh |

## Verification
The checker assumes three things about the inputs. The clock-stable input is meaningful only when it is sampled in the wait state. Requests arrive as single-cycle pulses. Reset is asserted from the first clock edge. The stimulus holds clock-stable high except during the wait windows it is testing, and drives every request for exactly one cycle between falling edges. Its stray pulses fall only into states where they must be dropped, which lets the timing properties measure their windows from the rising clock enable alone.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ENTER    = 3'd1,
        ST_IN_SR    = 3'd2,
        ST_WAIT_CLK = 3'd3,
        ST_EXIT_NOP = 3'd4,
        ST_READY    = 3'd5
    } sr_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sr_cmd_t;

    localparam sr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    typedef struct packed {
        logic    cke;
        sr_cmd_t cmd;
        logic    cmd_en;
        logic    rd_en;
        logic    sr_ack;
    } sr_out_t;

    // Length of the NOP-only window after the clock enable rises.
    function automatic int unsigned sr_nop_len(input int unsigned txsnr,
                                               input int unsigned dll_cyc,
                                               input bit          cons);
        if (cons || txsnr >= dll_cyc)
            return dll_cyc;
        else if (txsnr == 0)
            return 1;
        else
            return txsnr;
    endfunction

    function automatic sr_out_t sr_decode(input sr_state_t s);
        sr_out_t o;
        o = '{cke: 1'b1, cmd: CMD_NOP, cmd_en: 1'b0, rd_en: 1'b0, sr_ack: 1'b0};
        case (s)
            ST_IDLE: begin
                o.cmd_en = 1'b1;
                o.rd_en  = 1'b1;
            end
            ST_ENTER: begin
                o.cke = 1'b0;
                o.cmd = CMD_REF;
            end
            ST_IN_SR, ST_WAIT_CLK: begin
                o.cke    = 1'b0;
                o.sr_ack = 1'b1;
            end
            ST_EXIT_NOP: o.cke = 1'b1;
            ST_READY:    o.cmd_en = 1'b1;
            default:     o.cke = 1'b1;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/sr_seq_timer.sv
module sr_seq_timer #(
    parameter int unsigned NOP_LEN = 10,
    parameter int unsigned DLL_CYC = 200,
    localparam int unsigned CNT_W  = $clog2(DLL_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic nop_last,
    output logic dll_last
);
    localparam logic [CNT_W-1:0] NOP_END = CNT_W'(NOP_LEN - 1);
    localparam logic [CNT_W-1:0] DLL_END = CNT_W'(DLL_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DLL_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (run && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign nop_last = run && (cnt_q == NOP_END);
    assign dll_last = run && (cnt_q == DLL_END);
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
    import sr_seq_pkg::*;
#(
    parameter bit SKIP_READY = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_req,
    input  logic      wake_req,
    input  logic      clk_stable,
    input  logic      nop_last,
    input  logic      dll_last,
    output sr_state_t state
);
    sr_state_t state_q, state_d;
    logic      wake_held_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (sleep_req) state_d = ST_ENTER;
            ST_ENTER:    state_d = ST_IN_SR;
            ST_IN_SR:    if (wake_req || wake_held_q) state_d = ST_WAIT_CLK;
            ST_WAIT_CLK: if (clk_stable) state_d = ST_EXIT_NOP;
            ST_EXIT_NOP: if (nop_last) state_d = SKIP_READY ? ST_IDLE : ST_READY;
            ST_READY:    if (dll_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            wake_held_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ENTER && wake_req)
                wake_held_q <= 1'b1;
            else if (state_q == ST_IN_SR)
                wake_held_q <= 1'b0;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/sr_seq_outdec.sv
module sr_seq_outdec
    import sr_seq_pkg::*;
(
    input  sr_state_t state,
    output sr_out_t   pins
);
    assign pins = sr_decode(state);
endmodule

// File: rtl/sr_seq_top.sv
module sr_seq_top
    import sr_seq_pkg::*;
#(
    parameter int unsigned TXSNR        = 10,
    parameter int unsigned DLL_CYC      = 200,
    parameter bit          CONSERVATIVE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic clk_stable,
    output logic mem_cke,
    output logic mem_cs_n,
    output logic mem_ras_n,
    output logic mem_cas_n,
    output logic mem_we_n,
    output logic cmd_en,
    output logic rd_en,
    output logic sr_ack
);
    localparam int unsigned NOP_LEN   = sr_nop_len(TXSNR, DLL_CYC, CONSERVATIVE);
    localparam bit          NO_READY  = (NOP_LEN >= DLL_CYC);

    sr_state_t state;
    sr_out_t   pins;
    logic      nop_last, dll_last;
    logic      tmr_clr, tmr_run;

    assign tmr_clr = (state == ST_WAIT_CLK);
    assign tmr_run = (state == ST_EXIT_NOP) || (state == ST_READY);

    sr_seq_fsm #(.SKIP_READY(NO_READY)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sleep_req),
        .wake_req   (wake_req),
        .clk_stable (clk_stable),
        .nop_last   (nop_last),
        .dll_last   (dll_last),
        .state      (state)
    );

    sr_seq_timer #(.NOP_LEN(NOP_LEN), .DLL_CYC(DLL_CYC)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .clr      (tmr_clr),
        .run      (tmr_run),
        .nop_last (nop_last),
        .dll_last (dll_last)
    );

    sr_seq_outdec u_dec (
        .state (state),
        .pins  (pins)
    );

    assign mem_cke   = pins.cke;
    assign mem_cs_n  = pins.cmd.cs_n;
    assign mem_ras_n = pins.cmd.ras_n;
    assign mem_cas_n = pins.cmd.cas_n;
    assign mem_we_n  = pins.cmd.we_n;
    assign cmd_en    = pins.cmd_en;
    assign rd_en     = pins.rd_en;
    assign sr_ack    = pins.sr_ack;
endmodule

// File: rtl/sr_seq_chk.sv
module sr_seq_chk
    import sr_seq_pkg::*;
#(
    parameter int unsigned TXSNR        = 10,
    parameter int unsigned DLL_CYC      = 200,
    parameter bit          CONSERVATIVE = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic clk_stable,
    input logic mem_cke,
    input logic mem_cs_n,
    input logic mem_ras_n,
    input logic mem_cas_n,
    input logic mem_we_n,
    input logic cmd_en,
    input logic rd_en,
    input logic sr_ack
);
    localparam int unsigned NOP_LEN = sr_nop_len(TXSNR, DLL_CYC, CONSERVATIVE);

    logic [3:0]  cmd_w;
    logic        cke_q;
    int unsigned age_q, age_now;

    assign cmd_w   = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    assign age_now = (mem_cke && !cke_q) ? 0 : age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q <= 1'b1;
            age_q <= DLL_CYC;
        end else begin
            cke_q <= mem_cke;
            age_q <= (age_now < DLL_CYC) ? age_now + 1 : DLL_CYC;
        end
    end

    a_r1_enter_is_refresh: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cke) |-> cmd_w == CMD_REF);

    a_r2_parked_nop: assert property (@(posedge clk) disable iff (rst)
        (!mem_cke && $past(!mem_cke)) |-> (cmd_w == CMD_NOP && !cmd_en && !rd_en));

    a_r2_ack_low_cke: assert property (@(posedge clk) disable iff (rst)
        sr_ack |-> !mem_cke);

    a_r3_stable_first: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cke) |-> $past(clk_stable));

    a_r4_nop_window: assert property (@(posedge clk) disable iff (rst)
        (mem_cke && !cmd_en) |-> cmd_w == CMD_NOP);

    a_r4_cmd_gate: assert property (@(posedge clk) disable iff (rst)
        cmd_en |-> age_now >= NOP_LEN);

    a_r5_read_gate: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (cmd_en && age_now >= DLL_CYC));

    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> (mem_cke && cmd_w == CMD_NOP && cmd_en && rd_en && !sr_ack));
endmodule

bind sr_seq_top sr_seq_chk #(
    .TXSNR        (TXSNR),
    .DLL_CYC      (DLL_CYC),
    .CONSERVATIVE (CONSERVATIVE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_stable (clk_stable),
    .mem_cke    (mem_cke),
    .mem_cs_n   (mem_cs_n),
    .mem_ras_n  (mem_ras_n),
    .mem_cas_n  (mem_cas_n),
    .mem_we_n   (mem_we_n),
    .cmd_en     (cmd_en),
    .rd_en      (rd_en),
    .sr_ack     (sr_ack)
);

// File: tb/sim_sr_seq_top.sv
module sim_sr_seq_top;
    localparam int TXSNR = 10;
    localparam int DLL   = 200;
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] REF = 4'b0001;
    localparam int NVEC = 4;
    localparam int unsigned V_HOLD [NVEC] = '{0, 3, 1, 7};
    localparam int unsigned V_DLY  [NVEC] = '{0, 5, 1, 2};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0, wake_req = 1'b0, clk_stable = 1'b1;
    logic cke0, cs0, ras0, cas0, we0, cen0, ren0, ack0;
    logic cke1, cs1, ras1, cas1, we1, cen1, ren1, ack1;
    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    sr_seq_top #(.TXSNR(TXSNR), .DLL_CYC(DLL), .CONSERVATIVE(1'b0)) u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
        .clk_stable(clk_stable), .mem_cke(cke0), .mem_cs_n(cs0), .mem_ras_n(ras0),
        .mem_cas_n(cas0), .mem_we_n(we0), .cmd_en(cen0), .rd_en(ren0), .sr_ack(ack0));

    sr_seq_top #(.TXSNR(TXSNR), .DLL_CYC(DLL), .CONSERVATIVE(1'b1)) u1 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
        .clk_stable(clk_stable), .mem_cke(cke1), .mem_cs_n(cs1), .mem_ras_n(ras1),
        .mem_cas_n(cas1), .mem_we_n(we1), .cmd_en(cen1), .rd_en(ren1), .sr_ack(ack1));

    wire [3:0] cmd0 = {cs0, ras0, cas0, we0};
    wire [3:0] cmd1 = {cs1, ras1, cas1, we1};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(cke0 && cmd0 == NOP && cen0 && ren0 && !ack0, req,
            {cke0, cmd0, cen0, ren0, ack0}, {1'b1, NOP, 3'b110});
        chk(cke1 && cmd1 == NOP && cen1 && ren1 && !ack1, req,
            {cke1, cmd1, cen1, ren1, ack1}, {1'b1, NOP, 3'b110});
    endtask

    // Enters self-refresh, holds, wakes, waits for the clock, then measures exit windows.
    task automatic cycle_sr(input int hold, input int dly, input bit poke_sleep);
        int fc0 = -1, fr0 = -1, fc1 = -1, fr1 = -1;
        bit cke_drop = 1'b0, nop_bad = 1'b0;
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        chk(!cke0 && cmd0 == REF && !cke1 && cmd1 == REF, "R1 entry", {cke0, cmd0}, {1'b0, REF});
        @(negedge clk);
        chk(!cke0 && ack0 && cmd0 == NOP && !cen0 && !ren0, "R2 in self-refresh",
            {cke0, ack0, cmd0, cen0, ren0}, {2'b01, NOP, 2'b00});
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(!cke0 && ack0 && cmd0 == NOP && !cen0, "R2 hold", {cke0, cmd0}, {1'b0, NOP});
        end
        clk_stable = 1'b0; wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        for (int d = 0; d < dly; d++) begin
            chk(!cke0 && !cke1, "R3 clock not stable", cke0, 0);
            @(negedge clk);
        end
        chk(!cke0, "R3 before stable", cke0, 0);
        clk_stable = 1'b1;
        @(negedge clk);
        chk(cke0 && cke1, "R3 cke rises", cke0, 1);
        for (int k = 0; k <= DLL + 4; k++) begin
            if (cen0 && fc0 < 0) fc0 = k;
            if (ren0 && fr0 < 0) fr0 = k;
            if (cen1 && fc1 < 0) fc1 = k;
            if (ren1 && fr1 < 0) fr1 = k;
            if (!cke0 || !cke1) cke_drop = 1'b1;
            if ((!cen0 && cmd0 != NOP) || (!cen1 && cmd1 != NOP)) nop_bad = 1'b1;
            sleep_req = poke_sleep && (k == 20);
            @(negedge clk);
        end
        sleep_req = 1'b0;
        chk(!nop_bad, "R4 NOP during window", nop_bad, 0);
        chk(fc0 == TXSNR, "R4 cmd_en delay", fc0, TXSNR);
        chk(fr0 == DLL, "R5 rd_en delay", fr0, DLL);
        chk(fc1 == DLL, "R6 conservative cmd_en delay", fc1, DLL);
        chk(fr1 == DLL, "R6 conservative rd_en delay", fr1, DLL);
        chk(!cke_drop, poke_sleep ? "R8 sleep during exit ignored" : "R3 cke stays high",
            cke_drop, 0);
        chk_idle(poke_sleep ? "R8 back to idle" : "R5 back to idle");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R9 reset state");
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++)
            cycle_sr(int'(V_HOLD[i]), int'(V_DLY[i]), 1'b0);

        // R7: wake pulse in the entry cycle is held.
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0; wake_req = 1'b1;
        chk(!cke0 && cmd0 == REF, "R7 entry cycle", {cke0, cmd0}, {1'b0, REF});
        @(negedge clk); wake_req = 1'b0;
        chk(!cke0 && ack0, "R7 self-refresh reached", {cke0, ack0}, 2'b01);
        @(negedge clk);
        chk(!cke0, "R7 waiting on clock", cke0, 0);
        @(negedge clk);
        chk(cke0 && !cen0, "R7 exit without second wake", {cke0, cen0}, 2'b10);
        repeat (DLL + 2) @(negedge clk);
        chk_idle("R7 completes");

        // R8: wake in idle ignored.
        @(negedge clk); wake_req = 1'b1;
        @(negedge clk); wake_req = 1'b0;
        for (int j = 0; j < 3; j++) begin
            chk_idle("R8 wake in idle ignored");
            @(negedge clk);
        end

        // R8: sleep pulse during exit ignored.
        cycle_sr(1, 0, 1'b1);

        // R9: reset from inside self-refresh.
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
        @(negedge clk);
        chk(ack0 && !cke0, "R9 pre-reset in self-refresh", ack0, 1);
        rst = 1'b1;
        @(negedge clk);
        chk_idle("R9 mid-run reset");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R9 stays idle");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule